// File: doc/BRIEF.md
# VP9 Superframe Header Inserter

This block takes one compressed VP9 access unit as a byte stream, holds it in a local buffer, and splits it into its frames. The split uses the superframe index that may trail the unit. Each frame leaves the block behind a 16-byte prefix. The prefix carries the frame length plus four, the complement of that length, a fixed sync word and a four-character tag. The trailing index is not passed on. A downstream decoder that expects this prefix can then take the frames one at a time.

The unit arrives on a valid/ready byte interface, and a last flag marks its final byte. The block emits nothing until the whole unit is stored. It then sends the prefixed frames on a valid/ready byte interface whose last flag marks the final byte. After that it raises a single-cycle done strobe that carries the rewritten length. A unit that does not fit the buffer, or whose rewritten length would reach the output capacity, gives no output bytes. It only produces a done strobe with length zero.

Top module: `sfhdr_inserter`

## Requirements
- R1: The final byte of a unit is taken as an index marker when its bits [7:5] are 3'b110. Its bits [2:0] plus one give the frame count. Its bits [4:3] plus one give the width in bytes of each size field.
- R2: The index is accepted only if the unit is at least width×count+2 bytes long and the byte at offset length−width×count−2 equals the marker. Otherwise the whole unit, its final byte included, is one frame whose size is the unit length.
- R3: Under an accepted index, each frame size is read least significant byte first from the bytes that follow the leading marker copy. The frames are taken back to back from offset 0 in index order, and no index byte reaches the output.
- R4: Each frame is sent after a 16-byte prefix. Bytes 0–3 hold (size+4) most significant byte first. Bytes 4–7 hold the bitwise complement of bytes 0–3. Bytes 8–11 are 00 00 00 01. Bytes 12–15 are the TAG parameter, most significant byte first (default 32'h414D4C56).
- R5: One cycle after the final output byte is accepted, done is high for exactly one cycle, with a length equal to the sum of the frame sizes plus 16 times the frame count.
- R6: When that length would be greater than or equal to OUT_CAP, no byte is sent and done reports length 0.
- R7: A unit longer than DEPTH bytes sends no byte. Its done strobe reports length 0 with the oversize flag high in the same cycle. The next unit is processed normally.
- R8: While output valid is high and ready is low, the output byte and last flag hold. The last flag is high only on the final byte. Input ready is low from the acceptance of the final input byte until done.
- R9: A frame of size zero is sent as its 16-byte prefix alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block accepts an input byte |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Final byte of the unit |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Sink accepts an output byte |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Final output byte of the unit |
| doneValid | output | 1 | Single-cycle end-of-unit strobe |
| doneLen | output | $clog2(OUT_CAP+1) | Rewritten length, 0 on rejection |
| oversize | output | 1 | Unit exceeded DEPTH, valid with doneValid |

## Verification
The hardest cases to reach are a last byte that looks like a marker but fails validation, and a rewritten length that lands exactly on the capacity. One stimulus is a unit whose echo byte differs from its marker. Another is a two-byte unit too short to hold the index it claims. Capacity is tested with a pair of units. Eight empty frames give exactly OUT_CAP and must be rejected. Seven frames that total one byte less must pass. Zero-size frames in the middle of a superframe are checked for a lone prefix, and all output checks run under varying ready stalls.

// File: rtl/sfhdr_pkg.sv
package sfhdr_pkg;
  localparam int MAX_FRAMES = 8;
  localparam int HDR_BYTES = 16;

  typedef enum logic [2:0] {
    ST_FILL, ST_DECIDE, ST_PARSE, ST_CHECK, ST_HDR, ST_DATA, ST_DONE
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrByte;
    logic clrUnit;
    logic setSingle;
    logic ldIndex;
    logic accSize;
    logic rdAdv;
    logic rdRst;
  } strobe_t;
endpackage

// File: rtl/sfhdr_dpath.sv
module sfhdr_dpath import sfhdr_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int OUT_CAP = 128,
  parameter logic [31:0] TAG = 32'h414D4C56,
  localparam int LENW = $clog2(OUT_CAP + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [2:0]      frmIdx,
  input  logic [1:0]      magIdx,
  input  logic [3:0]      hdrIdx,
  input  logic            inHdr,
  input  logic [7:0]      inData,
  output logic [7:0]      outByte,
  output logic            indexOk,
  output logic            tooLong,
  output logic            overCap,
  output logic [2:0]      magW,
  output logic [3:0]      frames,
  output logic [31:0]     curSize,
  output logic [LENW-1:0] totalLen
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 2);
  localparam int TW = 36;

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wrCnt;
  logic [7:0]    lastByte;
  logic [31:0]   rdPtr;
  logic [31:0]   fsz [MAX_FRAMES];
  logic [TW-1:0] total;

  // marker decode and echo check
  logic        isMark;
  logic [3:0]  nFr;
  logic [5:0]  idxBytes;
  logic [31:0] idxStart;
  logic [7:0]  echo, rdByte, hdrByte;
  logic [31:0] sh, word;

  assign isMark   = (lastByte[7:5] == 3'b110);
  assign nFr      = {1'b0, lastByte[2:0]} + 4'd1;
  assign magW     = {1'b0, lastByte[4:3]} + 3'd1;
  assign idxBytes = 6'(magW) * 6'(nFr) + 6'd2;
  assign idxStart = 32'(wrCnt) - 32'(idxBytes);
  assign tooLong  = 32'(wrCnt) > 32'(DEPTH);
  assign echo     = (idxStart < 32'(DEPTH)) ? mem[idxStart[AW-1:0]] : 8'h00;
  assign indexOk  = isMark && !tooLong && (32'(wrCnt) >= 32'(idxBytes)) && (echo == lastByte);
  assign rdByte   = (rdPtr < 32'(DEPTH)) ? mem[rdPtr[AW-1:0]] : 8'h00;
  assign sh       = 32'(rdByte) << {magIdx, 3'b000};
  assign curSize  = fsz[frmIdx];
  assign overCap  = total >= TW'(OUT_CAP);
  assign totalLen = LENW'(total);
  assign word     = curSize + 32'd4;

  always_comb begin
    unique case (hdrIdx[3:2])
      2'd0: hdrByte = word[{~hdrIdx[1:0], 3'b000} +: 8];
      2'd1: hdrByte = ~word[{~hdrIdx[1:0], 3'b000} +: 8];
      2'd2: hdrByte = (hdrIdx[1:0] == 2'd3) ? 8'h01 : 8'h00;
      default: hdrByte = TAG[{~hdrIdx[1:0], 3'b000} +: 8];
    endcase
  end
  assign outByte = inHdr ? hdrByte : rdByte;

  always_ff @(posedge clk) begin
    if (stb.wrByte && wrCnt < CW'(DEPTH)) mem[wrCnt[AW-1:0]] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt <= '0; lastByte <= '0; rdPtr <= '0; total <= '0; frames <= '0;
      for (int i = 0; i < MAX_FRAMES; i++) fsz[i] <= '0;
    end else begin
      if (stb.clrUnit) begin
        wrCnt <= '0; total <= '0; frames <= '0;
        for (int i = 0; i < MAX_FRAMES; i++) fsz[i] <= '0;
      end
      if (stb.wrByte) begin
        lastByte <= inData;
        if (wrCnt <= CW'(DEPTH)) wrCnt <= wrCnt + 1'b1;
      end
      if (stb.setSingle) begin
        fsz[0] <= 32'(wrCnt);
        total  <= TW'(wrCnt) + TW'(HDR_BYTES);
        frames <= 4'd1;
      end
      if (stb.ldIndex) begin
        rdPtr  <= idxStart + 32'd1;
        total  <= TW'({nFr, 4'b0000});
        frames <= nFr;
      end
      if (stb.accSize) begin
        fsz[frmIdx] <= fsz[frmIdx] | sh;
        total       <= total + TW'(sh);
      end
      if (stb.rdRst) rdPtr <= '0;
      else if (stb.rdAdv) rdPtr <= rdPtr + 32'd1;
    end
  end
endmodule

// File: rtl/sfhdr_ctrl.sv
module sfhdr_ctrl import sfhdr_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        outReady,
  input  logic        indexOk,
  input  logic        tooLong,
  input  logic        overCap,
  input  logic [2:0]  magW,
  input  logic [3:0]  frames,
  input  logic [31:0] curSize,
  output strobe_t     stb,
  output logic [2:0]  frmIdx,
  output logic [1:0]  magIdx,
  output logic [3:0]  hdrIdx,
  output logic        inHdr,
  output logic        inReady,
  output logic        outValid,
  output logic        outLast,
  output logic        doneValid,
  output logic        rejected
);
  state_t      state;
  logic [31:0] dataCnt;
  logic        lastFrame, hdrEnd, dataEnd, fire;

  assign inReady   = (state == ST_FILL);
  assign inHdr     = (state == ST_HDR);
  assign outValid  = (state == ST_HDR) || (state == ST_DATA);
  assign doneValid = (state == ST_DONE);
  assign lastFrame = ({1'b0, frmIdx} == frames - 4'd1);
  assign hdrEnd    = (hdrIdx == 4'd15);
  assign dataEnd   = (dataCnt == curSize - 32'd1);
  assign fire      = outValid && outReady;
  assign outLast   = lastFrame && ((inHdr && hdrEnd && curSize == 32'd0) ||
                                   (state == ST_DATA && dataEnd));

  always_comb begin
    stb           = '0;
    stb.wrByte    = (state == ST_FILL) && inValid;
    stb.clrUnit   = (state == ST_DONE);
    stb.setSingle = (state == ST_DECIDE) && !tooLong && !indexOk;
    stb.ldIndex   = (state == ST_DECIDE) && !tooLong && indexOk;
    stb.accSize   = (state == ST_PARSE);
    stb.rdAdv     = (state == ST_PARSE) || ((state == ST_DATA) && fire);
    stb.rdRst     = (state == ST_CHECK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_FILL; frmIdx <= '0; magIdx <= '0; hdrIdx <= '0;
      dataCnt <= '0; rejected <= 1'b0;
    end else begin
      unique case (state)
        ST_FILL: if (inValid && inLast) state <= ST_DECIDE;
        ST_DECIDE: begin
          frmIdx <= '0; magIdx <= '0;
          if (tooLong) begin rejected <= 1'b1; state <= ST_DONE; end
          else if (indexOk) state <= ST_PARSE;
          else state <= ST_CHECK;
        end
        ST_PARSE: begin
          if ({1'b0, magIdx} == magW - 3'd1) begin
            magIdx <= '0;
            if (lastFrame) begin frmIdx <= '0; state <= ST_CHECK; end
            else frmIdx <= frmIdx + 3'd1;
          end else magIdx <= magIdx + 2'd1;
        end
        ST_CHECK: begin
          frmIdx <= '0; hdrIdx <= '0; dataCnt <= '0;
          if (overCap) begin rejected <= 1'b1; state <= ST_DONE; end
          else state <= ST_HDR;
        end
        ST_HDR: if (fire) begin
          if (hdrEnd) begin
            hdrIdx <= '0;
            if (curSize != 32'd0) begin dataCnt <= '0; state <= ST_DATA; end
            else if (lastFrame) state <= ST_DONE;
            else frmIdx <= frmIdx + 3'd1;
          end else hdrIdx <= hdrIdx + 4'd1;
        end
        ST_DATA: if (fire) begin
          if (dataEnd) begin
            if (lastFrame) state <= ST_DONE;
            else begin frmIdx <= frmIdx + 3'd1; state <= ST_HDR; end
          end else dataCnt <= dataCnt + 32'd1;
        end
        default: begin rejected <= 1'b0; state <= ST_FILL; end
      endcase
    end
  end
endmodule

// File: rtl/sfhdr_inserter.sv
module sfhdr_inserter import sfhdr_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int OUT_CAP = 128,
  parameter logic [31:0] TAG = 32'h414D4C56,
  localparam int LENW = $clog2(OUT_CAP + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [7:0]      inData,
  input  logic            inLast,
  output logic            outValid,
  input  logic            outReady,
  output logic [7:0]      outData,
  output logic            outLast,
  output logic            doneValid,
  output logic [LENW-1:0] doneLen,
  output logic            oversize
);
  strobe_t         stb;
  logic [2:0]      frmIdx, magW;
  logic [1:0]      magIdx;
  logic [3:0]      hdrIdx, frames;
  logic            inHdr, indexOk, tooLong, overCap, rejected;
  logic [31:0]     curSize;
  logic [LENW-1:0] totalLen;

  sfhdr_ctrl u_ctrl (
    .clk, .rstN, .inValid, .inLast, .outReady, .indexOk, .tooLong, .overCap,
    .magW, .frames, .curSize, .stb, .frmIdx, .magIdx, .hdrIdx, .inHdr,
    .inReady, .outValid, .outLast, .doneValid, .rejected
  );

  sfhdr_dpath #(.DEPTH(DEPTH), .OUT_CAP(OUT_CAP), .TAG(TAG)) u_dpath (
    .clk, .rstN, .stb, .frmIdx, .magIdx, .hdrIdx, .inHdr, .inData,
    .outByte(outData), .indexOk, .tooLong, .overCap, .magW, .frames,
    .curSize, .totalLen
  );

  assign doneLen  = (doneValid && !rejected) ? totalLen : '0;
  assign oversize = doneValid && tooLong;
endmodule

// File: rtl/sfhdr_chk.sv
module sfhdr_chk #(
  parameter int OUT_CAP = 128,
  localparam int LENW = $clog2(OUT_CAP + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [7:0]      outData,
  input logic            outLast,
  input logic            doneValid,
  input logic [LENW-1:0] doneLen,
  input logic            oversize
);
  // R8
  in_out_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));
  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R5
  done_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> doneValid);
  // R6
  done_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (32'(doneLen) < 32'(OUT_CAP)));
  // R7
  oversize_chk: assert property (@(posedge clk) disable iff (!rstN)
    oversize |-> (doneValid && doneLen == '0));
endmodule

bind sfhdr_inserter sfhdr_chk #(.OUT_CAP(OUT_CAP)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outLast(outLast),
  .doneValid(doneValid), .doneLen(doneLen), .oversize(oversize)
);

// File: tb/sfhdr_inserter_bench.sv
`timescale 1ns/1ps
module sfhdr_inserter_bench;
  localparam int DEPTH = 64;
  localparam int OUT_CAP = 128;
  localparam int LENW = $clog2(OUT_CAP + 1);
  localparam logic [31:0] TAG = 32'h414D4C56;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady, outValid, outLast, doneValid, oversize;
  logic [7:0] outData;
  logic [LENW-1:0] doneLen;

  int checks = 0, failures = 0;
  logic [7:0] unit[$];
  logic [8:0] got[$];
  logic [7:0] expQ[$];
  int expLen, expOver;
  int szA[8];

  always #4 clk = ~clk;

  sfhdr_inserter #(.DEPTH(DEPTH), .OUT_CAP(OUT_CAP), .TAG(TAG)) u_sfhdr_inserter (
    .clk, .rstN, .inValid, .inReady, .inData, .inLast, .outValid, .outReady,
    .outData, .outLast, .doneValid, .doneLen, .oversize
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected output computed from the requirements
  task automatic model();
    int n, c, g, ib, p, cnt, tot, off;
    int sz[8];
    logic [7:0] m;
    logic [31:0] w;
    n = unit.size();
    expQ.delete(); expLen = 0; expOver = 0;
    if (n > DEPTH) begin expOver = 1; return; end
    m = unit[n-1]; cnt = 1; sz[0] = n;
    if (m[7:5] == 3'b110) begin
      c = int'(m[2:0]) + 1; g = int'(m[4:3]) + 1; ib = g * c + 2;
      if (n >= ib && unit[n-ib] == m) begin
        cnt = c; p = n - ib + 1;
        for (int f = 0; f < c; f++) begin
          sz[f] = 0;
          for (int b = 0; b < g; b++) begin sz[f] |= int'(unit[p]) << (8 * b); p++; end
        end
      end
    end
    tot = 16 * cnt;
    for (int f = 0; f < cnt; f++) tot += sz[f];
    if (tot >= OUT_CAP) return;
    expLen = tot; off = 0;
    for (int f = 0; f < cnt; f++) begin
      w = 32'(sz[f] + 4);
      for (int k = 0; k < 4; k++) expQ.push_back(w[8*(3-k) +: 8]);
      for (int k = 0; k < 4; k++) expQ.push_back(~w[8*(3-k) +: 8]);
      expQ.push_back(8'h00); expQ.push_back(8'h00); expQ.push_back(8'h00); expQ.push_back(8'h01);
      for (int k = 0; k < 4; k++) expQ.push_back(TAG[8*(3-k) +: 8]);
      for (int i = 0; i < sz[f]; i++) begin expQ.push_back(unit[off]); off++; end
    end
  endtask

  task automatic buildSuper(int cnt, int g);
    int dat;
    logic [7:0] m;
    unit.delete(); dat = 0;
    for (int f = 0; f < cnt; f++) dat += szA[f];
    for (int i = 0; i < dat; i++) unit.push_back(8'(i * 13 + 5));
    m = 8'hC0 | 8'((g - 1) << 3) | 8'(cnt - 1);
    unit.push_back(m);
    for (int f = 0; f < cnt; f++)
      for (int b = 0; b < g; b++) unit.push_back(8'(szA[f] >> (8 * b)));
    unit.push_back(m);
  endtask

  task automatic buildPlain(int n, int base);
    unit.delete();
    for (int i = 0; i < n; i++) unit.push_back(8'(base + i));
  endtask

  // sends the unit, collects output under a ready pattern and checks everything
  task automatic runUnit(string req, int mode);
    int cyc, lastXfer, doneCyc, gotLen, gotOver, n;
    bit prevStall, r, seenDone;
    logic [8:0] prevData;
    model();
    got.delete(); n = unit.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!inReady) @(negedge clk);
      inValid = 1'b1; inData = unit[i]; inLast = (i == n - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    chk(inReady == 1'b0, "R8", "inReady after final input byte", int'(inReady), 0);
    cyc = 0; lastXfer = -10; doneCyc = -1; prevStall = 0; prevData = '0;
    gotLen = 0; gotOver = 0; seenDone = 0;
    while (cyc < 3000 && !seenDone) begin
      if (cyc > 0) @(negedge clk);
      if (prevStall)
        chk(outValid && {outLast, outData} == prevData, "R8", "held under stall",
            int'({outLast, outData}), int'(prevData));
      if (doneValid) begin
        seenDone = 1; doneCyc = cyc; gotLen = int'(doneLen); gotOver = int'(oversize);
      end else begin
        r = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(cyc % 2) : 1'(cyc % 3 != 0);
        outReady = r;
        if (outValid && r) begin got.push_back({outLast, outData}); lastXfer = cyc; end
        prevStall = outValid && !r;
        prevData = {outLast, outData};
        cyc++;
      end
    end
    outReady = 1'b0;
    chk(seenDone, "R5", "done seen", int'(seenDone), 1);
    chk(got.size() == expQ.size(), req, "output byte count", got.size(), expQ.size());
    for (int i = 0; i < got.size() && i < expQ.size(); i++) begin
      chk(got[i][7:0] == expQ[i], req, $sformatf("byte %0d", i), int'(got[i][7:0]), int'(expQ[i]));
      chk(got[i][8] == (i == expQ.size() - 1), "R8", $sformatf("last flag at %0d", i),
          int'(got[i][8]), int'(i == expQ.size() - 1));
    end
    chk(gotLen == expLen, (expLen == 0) ? "R6" : "R5", "done length", gotLen, expLen);
    chk(gotOver == expOver, "R7", "oversize flag", gotOver, expOver);
    if (got.size() > 0)
      chk(doneCyc == lastXfer + 1, "R5", "done one cycle after last byte", doneCyc, lastXfer + 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(inReady == 1'b1, "R8", "reset inReady", int'(inReady), 1);
    chk(outValid == 1'b0, "R8", "reset outValid", int'(outValid), 0);
    chk(doneValid == 1'b0, "R5", "reset doneValid", int'(doneValid), 0);
  endtask

  task automatic t_plain();      buildPlain(10, 16); runUnit("R4", 1); endtask
  task automatic t_superPair();  szA[0] = 5; szA[1] = 3; buildSuper(2, 1); runUnit("R3", 2); endtask
  task automatic t_zeroFrame();  szA[0] = 6; szA[1] = 0; szA[2] = 2; buildSuper(3, 2); runUnit("R9", 1); endtask
  task automatic t_wideField();  szA[0] = 3; buildSuper(1, 4); runUnit("R1", 0); endtask
  task automatic t_badEcho();
    unit.delete(); unit = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'hC1};
    runUnit("R2", 2);
  endtask
  task automatic t_tooShort();   unit.delete(); unit = '{8'h00, 8'hC3}; runUnit("R2", 0); endtask
  task automatic t_capBelow();
    for (int i = 0; i < 7; i++) szA[i] = 0;
    szA[2] = 15; buildSuper(7, 1); runUnit("R6", 1);
  endtask
  task automatic t_capAt();      for (int i = 0; i < 8; i++) szA[i] = 0; buildSuper(8, 1); runUnit("R6", 0); endtask
  task automatic t_bigSize();    szA[0] = 200; buildSuper(1, 2); runUnit("R6", 0); endtask
  task automatic t_oversize();   buildPlain(70, 3); runUnit("R7", 0); endtask
  task automatic t_recover();    buildPlain(4, 200); runUnit("R7", 2); endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_plain();
    t_superPair();
    t_zeroFrame();
    t_wideField();
    t_badEcho();
    t_tooShort();
    t_capBelow();
    t_capAt();
    t_bigSize();
    t_oversize();
    t_recover();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule